// File: doc/BRIEF.md
# Bidirectional Parallel Port with Strobe Snapshot

This block is an 8-bit general-purpose parallel port in which every pin can be an input or an output under its own direction bit. Software writes an output latch, sets the direction mask and reads the port over a small register bus. The bus has an offset, separate write and read enables, and 8-bit write and read data. Each pin gets an output-enable and an output value, which an external pad driver combines with the incoming pin level.

An external strobe line lets a peripheral mark the moment its data is valid. The strobe passes through a two-flop synchronizer, and its rising edge is found on the synchronized signal. One cycle after the edge is found, the synchronized pin levels are copied into a separate read-only snapshot register. Software can read that snapshot at its leisure, while the live port value goes on changing.

Top module: `bidir_strobe_port`

## Requirements
- R1: After reset, the direction mask, the output latch and the snapshot register are all 0x00, so `pin_oe` and `pin_out` are 0x00.
- R2: A write to offset 7 sets the direction mask (bit value 1 = output, 0 = input). A read at offset 7 returns the mask. From the clock after the write, `pin_oe` equals the mask.
- R3: A write to offset 3 loads the output latch for all eight bits, including bits that are inputs. `pin_out` shows the latch from the next clock, so a later change of direction drives the stored value.
- R4: A read at offset 3 returns the latch bit for each output bit and the pin level, synchronized through two flops, for each input bit.
- R5: A rising edge on `strobe_in` copies the synchronized pin levels into the snapshot register, read at offset 5, within four clocks of the edge.
- R6: The snapshot keeps its captured value when the pins change afterwards. Reads at offset 5 return that value, not the live pins.
- R7: Writes to offset 5 leave the snapshot unchanged.
- R8: A falling edge on `strobe_in`, or a strobe held high, causes no capture.
- R9: Reads at offsets other than 3, 5 and 7 return 0x00. Writes at those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write enable |
| reg_rd | input | 1 | Read enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from offset and read enable |
| pin_in | input | 8 | Levels seen on the pins |
| pin_out | output | 8 | Output values for the pins |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |
| strobe_in | input | 1 | External capture strobe, asynchronous |

## Verification
A corrupted direction mask or output latch shows on `pin_oe` or `pin_out` at the very next clock, and in the offset 3 readback straight away. A broken synchronizer or edge detector shows as a snapshot that never changes, that changes on a falling edge, or that changes a cycle early or late. The snapshot is therefore checked against a pin value that has just been changed, a few clocks after each strobe edge. A snapshot that follows the live pins is caught by changing the pins after a capture and reading offset 5 again.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned OFS_W    = 3;
  localparam int unsigned OFS_DATA = 3;
  localparam int unsigned OFS_SNAP = 5;
  localparam int unsigned OFS_DIR  = 7;
endpackage

// File: rtl/pport_rst_sync.sv
// Reset synchronizer: asserts at once, releases after two clocks
module pport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;
endmodule

// File: rtl/pport_sync2.sv
// Two-flop synchronizer for a vector of independent bits
module pport_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pport_snap.sv
// Rising-edge detect on the synchronized strobe and delayed pin capture
module pport_snap #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strb_sync,
  input  logic [W-1:0] pins_sync,
  output logic [W-1:0] snap,
  output logic         cap_pend,
  output logic         strb_prev
);
  logic         prev_q, prev_d;
  logic         cap_q, cap_d;
  logic [W-1:0] snap_q, snap_d;
  logic         rise;

  always_comb begin
    rise   = strb_sync & ~prev_q;
    prev_d = strb_sync;
    cap_d  = rise;
    snap_d = cap_q ? pins_sync : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      prev_q <= prev_d;
      cap_q  <= cap_d;
      snap_q <= snap_d;
    end
  end

  assign snap      = snap_q;
  assign cap_pend  = cap_q;
  assign strb_prev = prev_q;
endmodule

// File: rtl/bidir_strobe_port.sv
module bidir_strobe_port
  import pport_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = OFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  input  logic          strobe_in
);
  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
  localparam logic [AW-1:0] A_SNAP = AW'(OFS_SNAP);
  localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);

  logic         rst_sn;
  logic [W-1:0] pins_sync;
  logic         strb_sync;
  logic [W-1:0] snap_q;
  logic         cap_q;
  logic         strb_prev;

  logic [W-1:0] dir_q, dir_d, out_q, out_d;
  logic         dir_we, out_we;

  pport_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pport_sync2 #(.W(W)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (pin_in),
    .q     (pins_sync)
  );

  pport_sync2 #(.W(1)) u_strb_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (strobe_in),
    .q     (strb_sync)
  );

  pport_snap #(.W(W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_sn),
    .strb_sync (strb_sync),
    .pins_sync (pins_sync),
    .snap      (snap_q),
    .cap_pend  (cap_q),
    .strb_prev (strb_prev)
  );

  // register write enables and next state
  always_comb begin
    dir_we = reg_wr && (reg_addr == A_DIR);
    out_we = reg_wr && (reg_addr == A_DATA);
    dir_d  = dir_we ? reg_wdata : dir_q;
    out_d  = out_we ? reg_wdata : out_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
    end
  end

  // read mux: output bits from the latch, input bits from the pins
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        A_DATA:  reg_rdata = (dir_q & out_q) | (~dir_q & pins_sync);
        A_SNAP:  reg_rdata = snap_q;
        A_DIR:   reg_rdata = dir_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/pport_chk.sv
module pport_chk
  import pport_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = OFS_W
) (
  input logic          clk,
  input logic          rst_sn,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic [W-1:0]  reg_wdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic [W-1:0]  pins_sync,
  input logic          strb_sync,
  input logic          strb_prev,
  input logic          cap_q,
  input logic [W-1:0]  snap_q
);
  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
  localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);

  // R2: direction write shows on the enables one clock later
  a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr == A_DIR) |=> (pin_oe == $past(reg_wdata)));

  // R3: data write shows on the output values one clock later
  a_r3_out_follows_write: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr == A_DATA) |=> (pin_out == $past(reg_wdata)));

  // R5: a pending capture copies the synchronized pins
  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_sn)
    cap_q |=> (snap_q == $past(pins_sync)));

  // R6 and R7: snapshot holds unless a capture is pending
  a_r7_snap_holds: assert property (@(posedge clk) disable iff (!rst_sn)
    !cap_q |=> $stable(snap_q));

  // R8: capture only after a low-to-high synchronized strobe
  a_r8_capture_needs_rise: assert property (@(posedge clk) disable iff (!rst_sn)
    cap_q |-> ($past(strb_sync) && !$past(strb_prev)));
endmodule

bind bidir_strobe_port pport_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pins_sync (pins_sync),
  .strb_sync (strb_sync),
  .strb_prev (strb_prev),
  .cap_q     (cap_q),
  .snap_q    (snap_q)
);

// File: tb/tb_bidir_strobe_port.sv
module tb_bidir_strobe_port;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] pin_in, pin_out, pin_oe;
  logic       strobe_in;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bidir_strobe_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .strobe_in(strobe_in)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1;
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    rd(3'd7, v); chk("R1 dir", v, 8'h00);
    rd(3'd5, v); chk("R1 snap", v, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    wr(3'd7, 8'hA5);
    #1 chk("R2 oe", pin_oe, 8'hA5);
    rd(3'd7, v); chk("R2 readback", v, 8'hA5);
    wr(3'd7, 8'h00);
    #1 chk("R2 oe clear", pin_oe, 8'h00);
  endtask

  task automatic t_data_write();
    wr(3'd3, 8'h3C);
    #1 chk("R3 out while input", pin_out, 8'h3C);
    chk("R3 oe still off", pin_oe, 8'h00);
    wr(3'd7, 8'hFF);
    #1 chk("R3 stored value driven", pin_out, 8'h3C);
    chk("R3 oe on", pin_oe, 8'hFF);
  endtask

  task automatic t_data_read();
    logic [7:0] v;
    wr(3'd7, 8'hF0);
    pin_in = 8'h96; idle(3);
    rd(3'd3, v); chk("R4 mixed 96", v, 8'h36);
    pin_in = 8'h69; idle(3);
    rd(3'd3, v); chk("R4 mixed 69", v, 8'h39);
    wr(3'd7, 8'h00);
    idle(1);
    rd(3'd3, v); chk("R4 all input", v, 8'h69);
  endtask

  task automatic t_strobe();
    logic [7:0] v;
    pin_in = 8'h5A; idle(3);
    strobe_in = 1'b1; idle(6);
    rd(3'd5, v); chk("R5 capture 5A", v, 8'h5A);
    pin_in = 8'hC3; idle(4);
    rd(3'd5, v); chk("R6 snap holds", v, 8'h5A);
    rd(3'd3, v); chk("R6 live pins", v, 8'hC3);
    strobe_in = 1'b0; idle(6);
    rd(3'd5, v); chk("R8 no capture on fall", v, 8'h5A);
    strobe_in = 1'b1; idle(6);
    rd(3'd5, v); chk("R5 capture C3", v, 8'hC3);
    pin_in = 8'h0F; idle(8);
    rd(3'd5, v); chk("R8 no capture while high", v, 8'hC3);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    wr(3'd5, 8'hFF);
    rd(3'd5, v); chk("R7 write ignored", v, 8'hC3);
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R7 write ignored zero", v, 8'hC3);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd4, 8'hFF); wr(3'd6, 8'hFF);
    #1 chk("R9 oe untouched", pin_oe, 8'hFF);
    chk("R9 out untouched", pin_out, 8'h3C);
    rd(3'd0, v); chk("R9 read 0", v, 8'h00);
    rd(3'd6, v); chk("R9 read 6", v, 8'h00);
    rd(3'd5, v); chk("R9 snap untouched", v, 8'hC3);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; pin_in = 8'h00; strobe_in = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_dir();
    t_data_write();
    t_data_read();
    t_strobe();
    t_ignore();
    wr(3'd7, 8'hFF);
    t_unmapped();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule